// File: doc/BRIEF.md
# Presence-Driven Operand Template Firing Unit

This block executes a small dataflow graph held in a local table of instruction templates. Each template stores an operation code, two destination references, an immediate value and two operand slots. Each operand slot has its own presence bit. Nothing steps through the table in order. A template runs as soon as every operand it needs has arrived, and at no other time.

Operand tokens enter through a valid/ready port. Each token carries a template index, a side bit (0 = left slot, 1 = right slot) and a data word. An accepted token is written into its slot and marks the slot present. A slot holds at most one pending value. A token aimed at an occupied slot is held off and raises a sticky error flag.

At most one ready template fires per cycle, and the lowest index wins. The block computes the integer result and clears both presence bits of the template. It queues one result token for the first destination and a second token for the second destination when that field is non-zero. Result tokens leave through a valid/ready port. Software or a loader fills the table through a single-cycle write port, and that write also empties the template's slots.

Top module: `tmpl_fire_unit`

## Requirements
- R1: After reset, `tout_valid` and `err_flag` are 0, and an input token is accepted (`tin_ready` = 1) for any slot.
- R2: A template with a two-operand code produces no output while only one of its operands is present. It fires once both are present.
- R3: Operation codes are 0 add, 1 subtract (left minus right), 2 multiply (low DW bits), 3 bitwise AND, 4 add-immediate (left plus stored immediate), 5 negate (two's complement of left), 6 pass (left unchanged) and 7 bitwise XOR. All results wrap to DW bits.
- R4: Codes 4, 5 and 6 fire with only the left operand present. The right slot is neither required nor consumed.
- R5: A destination field is {template index, side bit in the LSB}. On firing, the token for the first destination leaves before the token for the second. A second-destination field of all zeros produces no second token.
- R6: A token for a slot whose presence bit is set is refused (`tin_ready` = 0). The stored value is kept, and `err_flag` becomes 1 on the next edge and stays 1 until reset.
- R7: Firing clears both presence bits of the template on the same edge that queues its results, so the slots accept new tokens from the following cycle. A token offered to a slot during its template's firing cycle is refused.
- R8: When several templates are ready, they fire one per cycle in ascending index order.
- R9: A template fires only when the output queue has at least two free entries. While `tout_ready` is 0, the head token holds steady. No token is lost or reordered.
- R10: Writing a template through the configuration port clears both of its presence bits. A token to that template is refused in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Template write strobe |
| cfg_idx | input | IW | Template index written |
| cfg_op | input | 3 | Operation code |
| cfg_dst0 | input | IW+1 | First destination {index, side} |
| cfg_dst1 | input | IW+1 | Second destination; 0 = none |
| cfg_imm | input | DW | Immediate operand |
| tin_valid | input | 1 | Input token valid |
| tin_ready | output | 1 | Input token accepted |
| tin_idx | input | IW | Target template |
| tin_side | input | 1 | 0 left, 1 right |
| tin_data | input | DW | Operand value |
| tout_valid | output | 1 | Result token valid |
| tout_ready | input | 1 | Result token taken |
| tout_idx | output | IW | Destination template |
| tout_side | output | 1 | Destination side |
| tout_data | output | DW | Result value |
| err_flag | output | 1 | Sticky occupied-slot refusal |

## Verification
Two functions can meet in one cycle: a template firing, and a new token arriving for a slot of that same template. The bench provokes this by completing a pass template and offering the next left operand in the very next cycle, which is the firing cycle. It expects a refusal in that cycle, acceptance one cycle later, and two result tokens in order. Priority against backpressure is also checked. The output queue is filled while stalled and two templates are completed behind it. After release, the lower index must drain first.

// File: rtl/fu_pkg.sv
package fu_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_AND  = 3'd3,
        OP_ADDI = 3'd4,
        OP_NEG  = 3'd5,
        OP_PASS = 3'd6,
        OP_XOR  = 3'd7
    } fu_op_e;

    // codes that need only the left operand
    function automatic logic op_left_only(fu_op_e op);
        return (op == OP_ADDI) || (op == OP_NEG) || (op == OP_PASS);
    endfunction
endpackage

// File: rtl/fu_alu.sv
module fu_alu
    import fu_pkg::*;
#(
    parameter int DW = 16
) (
    input  fu_op_e          op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [DW-1:0]   imm,
    output logic [DW-1:0]   y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = a * b;
            OP_AND:  y = a & b;
            OP_ADDI: y = a + imm;
            OP_NEG:  y = '0 - a;
            OP_PASS: y = a;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/fu_pick.sv
module fu_pick #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N:0] seen;   // seen[i]: some request below i

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign gnt[i]    = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (gnt[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/fu_outq.sv
module fu_outq #(
    parameter int DEPTH = 4,
    parameter int W     = 20,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push0,
    input  logic [W-1:0]  din0,
    input  logic          push1,
    input  logic [W-1:0]  din1,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          nempty,
    output logic [PW:0]   free
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [PW:0]             cnt;
    } oq_t;

    oq_t q_q, q_d;

    assign head   = q_q.mem[q_q.rp];
    assign nempty = (q_q.cnt != '0);
    assign free   = (PW+1)'(DEPTH) - q_q.cnt;

    always_comb begin
        logic do_pop;
        q_d    = q_q;
        do_pop = pop && nempty;
        if (do_pop) q_d.rp = q_q.rp + 1'b1;
        if (push0) begin
            q_d.mem[q_q.wp] = din0;
            if (push1) begin
                q_d.mem[q_q.wp + 1'b1] = din1;
                q_d.wp = q_q.wp + 2'd2;
            end else begin
                q_d.wp = q_q.wp + 1'b1;
            end
        end
        q_d.cnt = q_q.cnt + (PW+1)'(push0) + (PW+1)'(push0 && push1)
                  - (PW+1)'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end
endmodule

// File: rtl/tmpl_fire_unit.sv
module tmpl_fire_unit
    import fu_pkg::*;
#(
    parameter int N      = 8,
    parameter int DW     = 16,
    parameter int QDEPTH = 4,
    localparam int IW    = (N > 1) ? $clog2(N) : 1,
    localparam int DSTW  = IW + 1,
    localparam int TW    = DSTW + DW,
    localparam int QPW   = $clog2(QDEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [IW-1:0]   cfg_idx,
    input  logic [2:0]      cfg_op,
    input  logic [DSTW-1:0] cfg_dst0,
    input  logic [DSTW-1:0] cfg_dst1,
    input  logic [DW-1:0]   cfg_imm,
    input  logic            tin_valid,
    output logic            tin_ready,
    input  logic [IW-1:0]   tin_idx,
    input  logic            tin_side,
    input  logic [DW-1:0]   tin_data,
    output logic            tout_valid,
    input  logic            tout_ready,
    output logic [IW-1:0]   tout_idx,
    output logic            tout_side,
    output logic [DW-1:0]   tout_data,
    output logic            err_flag
);
    typedef struct packed {
        fu_op_e [N-1:0]            op;
        logic   [N-1:0][DSTW-1:0]  dst0;
        logic   [N-1:0][DSTW-1:0]  dst1;
        logic   [N-1:0][DW-1:0]    imm;
        logic   [N-1:0][DW-1:0]    vl;
        logic   [N-1:0][DW-1:0]    vr;
        logic   [N-1:0]            pl;
        logic   [N-1:0]            pr;
        logic                      err;
    } st_t;

    st_t q, d;

    // ---------------- readiness and selection ----------------
    logic [N-1:0]    rdy_vec;
    logic [N-1:0]    fire_req;
    logic [N-1:0]    fire_gnt;
    logic [IW-1:0]   fire_idx;
    logic            fire_any;
    logic [QPW:0]    oq_free;
    logic            room;
    logic [N-1:0]    pres_l;

    for (genvar i = 0; i < N; i++) begin : g_rdy
        assign rdy_vec[i] = q.pl[i] & (q.pr[i] | op_left_only(q.op[i]));
    end

    assign room     = (oq_free >= (QPW+1)'(2));
    assign fire_req = room ? rdy_vec : '0;
    assign pres_l   = q.pl;

    fu_pick #(.N(N)) u_pick (
        .req (fire_req),
        .gnt (fire_gnt),
        .idx (fire_idx),
        .any (fire_any)
    );

    // ---------------- execution ----------------
    logic [DW-1:0] res;

    fu_alu #(.DW(DW)) u_alu (
        .op  (q.op[fire_idx]),
        .a   (q.vl[fire_idx]),
        .b   (q.vr[fire_idx]),
        .imm (q.imm[fire_idx]),
        .y   (res)
    );

    logic          push0, push1;
    logic [TW-1:0] tok0, tok1, head;
    logic          nempty;

    assign push0 = fire_any;
    assign push1 = fire_any && (q.dst1[fire_idx] != '0);
    assign tok0  = {q.dst0[fire_idx], res};
    assign tok1  = {q.dst1[fire_idx], res};

    fu_outq #(.DEPTH(QDEPTH), .W(TW)) u_outq (
        .clk    (clk),
        .rst_n  (rst_n),
        .push0  (push0),
        .din0   (tok0),
        .push1  (push1),
        .din1   (tok1),
        .pop    (tout_ready),
        .head   (head),
        .nempty (nempty),
        .free   (oq_free)
    );

    assign tout_valid = nempty;
    assign tout_idx   = head[TW-1 -: IW];
    assign tout_side  = head[DW];
    assign tout_data  = head[DW-1:0];
    assign err_flag   = q.err;

    // ---------------- token intake ----------------
    logic slot_busy, cfg_hit, tin_take;

    assign slot_busy = tin_side ? q.pr[tin_idx] : q.pl[tin_idx];
    assign cfg_hit   = cfg_we && (cfg_idx == tin_idx);
    assign tin_ready = !slot_busy && !cfg_hit;
    assign tin_take  = tin_valid && tin_ready;

    // ---------------- next state ----------------
    always_comb begin
        d = q;
        if (fire_any) begin
            d.pl[fire_idx] = 1'b0;
            d.pr[fire_idx] = 1'b0;
        end
        if (tin_take) begin
            if (tin_side) begin
                d.pr[tin_idx] = 1'b1;
                d.vr[tin_idx] = tin_data;
            end else begin
                d.pl[tin_idx] = 1'b1;
                d.vl[tin_idx] = tin_data;
            end
        end
        if (tin_valid && slot_busy && !cfg_hit) d.err = 1'b1;
        if (cfg_we) begin
            d.op[cfg_idx]   = fu_op_e'(cfg_op);
            d.dst0[cfg_idx] = cfg_dst0;
            d.dst1[cfg_idx] = cfg_dst1;
            d.imm[cfg_idx]  = cfg_imm;
            d.vl[cfg_idx]   = '0;
            d.vr[cfg_idx]   = '0;
            d.pl[cfg_idx]   = 1'b0;
            d.pr[cfg_idx]   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/fu_chk.sv
module fu_chk #(
    parameter int N  = 8,
    parameter int DW = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          tin_valid,
    input logic          tin_ready,
    input logic          err_flag,
    input logic          tout_valid,
    input logic          tout_ready,
    input logic [IW-1:0] tout_idx,
    input logic [DW-1:0] tout_data,
    input logic [N-1:0]  fire_gnt,
    input logic          fire_any,
    input logic [IW-1:0] fire_idx,
    input logic [N-1:0]  pres_l
);
    logic [IW-1:0] last_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_idx <= '0;
        else        last_idx <= fire_idx;
    end

    AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (tin_valid && !tin_ready && !cfg_we) |=> err_flag); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_valid && !tout_ready) |=>
            (tout_valid && $stable(tout_data) && $stable(tout_idx))); // R9

    AST_ONE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire_gnt)); // R8

    AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fire_any |=> !pres_l[last_idx]); // R7
endmodule

bind tmpl_fire_unit fu_chk #(.N(N), .DW(DW)) u_fu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .tin_valid  (tin_valid),
    .tin_ready  (tin_ready),
    .err_flag   (err_flag),
    .tout_valid (tout_valid),
    .tout_ready (tout_ready),
    .tout_idx   (tout_idx),
    .tout_data  (tout_data),
    .fire_gnt   (fire_gnt),
    .fire_any   (fire_any),
    .fire_idx   (fire_idx),
    .pres_l     (pres_l)
);

// File: tb/tb_tmpl_fire_unit.sv
`timescale 1ns/1ps
module tb_tmpl_fire_unit;
    localparam int N = 8, DW = 16, IW = 3, DSTW = 4, TW = DSTW + DW;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0; logic [IW-1:0] cfg_idx = 0; logic [2:0] cfg_op = 0;
    logic [DSTW-1:0] cfg_dst0 = 0, cfg_dst1 = 0; logic [DW-1:0] cfg_imm = 0;
    logic tin_valid = 0, tin_side = 0; logic [IW-1:0] tin_idx = 0;
    logic [DW-1:0] tin_data = 0;
    logic tin_ready, tout_valid, tout_side, err_flag;
    logic tout_ready = 0;
    logic [IW-1:0] tout_idx; logic [DW-1:0] tout_data;

    int n_chk = 0, n_bad = 0;
    logic [TW-1:0] exp_q [0:255];
    int wr = 0, rd = 0;

    always #10 clk = ~clk;

    tmpl_fire_unit dut (.*);

    function automatic logic [DW-1:0] model(input logic [2:0] op,
        input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] im);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return DW'(a * b);
            3'd3: return a & b;
            3'd4: return a + im;
            3'd5: return DW'(0) - a;
            3'd6: return a;
            default: return a ^ b;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_tok(input logic [DSTW-1:0] d0, input logic [DSTW-1:0] d1,
                              input logic [DW-1:0] v);
        exp_q[wr[7:0]] = {d0, v}; wr++;
        if (d1 != 0) begin exp_q[wr[7:0]] = {d1, v}; wr++; end
    endtask

    // collector: sampled well after the input-driving negedge
    always @(negedge clk) begin
        #2;
        if (tout_valid && tout_ready) begin
            if (rd == wr) check("R5 unexpected token", {tout_idx, tout_side, tout_data}, 32'hDEAD);
            else begin
                check("R3 R5 R8 R9 token", {tout_idx, tout_side, tout_data}, exp_q[rd[7:0]]);
                rd++;
            end
        end
    end

    task automatic load(input int idx, input logic [2:0] op, input logic [DSTW-1:0] d0,
                        input logic [DSTW-1:0] d1, input logic [DW-1:0] im);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_op = op; cfg_dst0 = d0; cfg_dst1 = d1; cfg_imm = im;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic send(input int idx, input logic side, input logic [DW-1:0] v);
        tin_valid = 1; tin_idx = IW'(idx); tin_side = side; tin_data = v;
        #1;
        for (int k = 0; k < 50 && !tin_ready; k++) begin @(negedge clk); #1; end
        @(negedge clk); tin_valid = 0;
    endtask

    task automatic try_once(input int idx, input logic side, input logic [DW-1:0] v,
                            output logic ok);
        tin_valid = 1; tin_idx = IW'(idx); tin_side = side; tin_data = v;
        #1; ok = tin_ready;
        @(negedge clk); tin_valid = 0;
    endtask

    task automatic drain;
        for (int k = 0; k < 100 && rd != wr; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R9 all tokens delivered", 32'(rd), 32'(wr));
    endtask

    initial begin
        #3000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic ok;
        logic [DW-1:0] a, b, im;
        logic [2:0] op;
        logic [DSTW-1:0] d0, d1;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R1 reset state
        check("R1 tout_valid", 32'(tout_valid), 0);
        check("R1 err_flag", 32'(err_flag), 0);
        check("R1 tin_ready", 32'(tin_ready), 1);
        tout_ready = 1;

        // R2: one operand of ADD is not enough
        load(1, 3'd0, 4'h4, 4'h7, 0);
        send(1, 0, 16'd100);
        repeat (4) @(negedge clk);
        check("R2 no fire with one operand", 32'(tout_valid), 0);
        expect_tok(4'h4, 4'h7, 16'd142);
        send(1, 1, 16'd42);
        drain();

        // random: R3 R4 R5
        for (int it = 0; it < 60; it++) begin
            int t;
            t  = int'($urandom_range(0, N-1));
            op = 3'($urandom_range(0, 7));
            a  = 16'($urandom); b = 16'($urandom); im = 16'($urandom);
            d0 = 4'($urandom);
            d1 = ($urandom_range(0, 2) == 0) ? 4'h0 : 4'($urandom);
            load(t, op, d0, d1, im);
            expect_tok(d0, d1, model(op, a, (op inside {3'd4, 3'd5, 3'd6}) ? 16'h0 : b, im));
            send(t, 0, a);
            if (!(op inside {3'd4, 3'd5, 3'd6})) send(t, 1, b);   // R4 left-only codes
            drain();
        end

        // R6: occupied slot refused, value kept, sticky error
        load(4, 3'd1, 4'h9, 4'h0, 0);
        send(4, 0, 16'd500);
        try_once(4, 0, 16'd7, ok);
        check("R6 refused", 32'(ok), 0);
        #1; check("R6 err set", 32'(err_flag), 1);
        expect_tok(4'h9, 4'h0, 16'd490);
        send(4, 1, 16'd10);
        drain();
        check("R6 err sticky", 32'(err_flag), 1);

        // R7: token offered in the firing cycle is refused, accepted next cycle
        load(5, 3'd6, 4'h3, 4'hB, 0);
        expect_tok(4'h3, 4'hB, 16'h1111);
        expect_tok(4'h3, 4'hB, 16'h2222);
        send(5, 0, 16'h1111);
        try_once(5, 0, 16'h2222, ok);
        check("R7 refused during fire", 32'(ok), 0);
        try_once(5, 0, 16'h2222, ok);
        check("R7 accepted after fire", 32'(ok), 1);
        drain();

        // R8 R9: fill queue while stalled, then two waiting templates
        tout_ready = 0;
        load(6, 3'd6, 4'h2, 4'h5, 0);
        expect_tok(4'h2, 4'h5, 16'hA1);
        expect_tok(4'h2, 4'h5, 16'hA2);
        send(6, 0, 16'hA1);
        repeat (2) @(negedge clk);
        send(6, 0, 16'hA2);
        load(7, 3'd5, 4'hE, 4'hF, 0);
        load(2, 3'd4, 4'h6, 4'h1, 16'd5);
        send(7, 0, 16'd3);
        send(2, 0, 16'd20);
        repeat (4) @(negedge clk); #1;
        check("R9 head held", 32'(tout_data), 32'hA1);
        check("R9 valid held", 32'(tout_valid), 1);
        expect_tok(4'h6, 4'h1, 16'd25);          // R8 index 2 before 7
        expect_tok(4'hE, 4'hF, 16'hFFFD);
        tout_ready = 1;
        drain();

        // R10: reconfiguration clears presence
        load(3, 3'd0, 4'h8, 4'h0, 0);
        send(3, 0, 16'd1);
        load(3, 3'd7, 4'hA, 4'h0, 0);
        try_once(3, 0, 16'h00F0, ok);
        check("R10 slot free after write", 32'(ok), 1);
        expect_tok(4'hA, 4'h0, 16'h00FF);
        send(3, 1, 16'h000F);
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule